// File: doc/BRIEF.md
# Panel power-up and standby sequencer

This block brings a display panel out of reset and through its initialization, and later puts it into standby or brings it back. It holds the panel's active-low reset line and waits out fixed millisecond delays with its own timer. It sends a fixed script of panel commands to an external serial command engine, one step at a time. Each step carries a command byte and zero, one or two parameter bytes. A step goes out on a valid/ready request. Then the block waits for the engine's done pulse before it moves to the next step.

Two plain request inputs start the work. `init_req` starts the full power-up: reset pulse, settle time, then the initialization script. `stby_req` starts the suspend script when `stby_suspend` is high and the resume script when it is low. `busy` is high while a sequence is running. The millisecond tick comes from the system clock through a divider set by `CLK_PER_MS`. The delay lengths are parameters, given in milliseconds.

Back-pressure rule: once `eng_valid` is high, it stays high and `eng_cmd`, `eng_param0`, `eng_param1` and `eng_pvalid` hold their values until a cycle in which `eng_ready` is also high. That cycle is the transfer. No new request is raised until `eng_done` has been seen for the transferred step.

Top module: `panel_seq_top`

## Requirements
- R1: After reset, `busy` is 0, `panel_rst_n` is 1 and `eng_valid` is 0.
- R2: An init sequence drives `panel_rst_n` low for exactly 2×`CLK_PER_MS` cycles. It then holds it high for exactly 10×`CLK_PER_MS` cycles before the first request. No request is raised while `panel_rst_n` is low.
- R3: The init script sends, in order: 0x29, then 0x11, with no parameters; 0x36 with 0x00; 0x3A with 0x70; 0xB0 with 0x00; 0xB8 with 0x00; 0xB9 with 0x01 then 0xFF. `eng_pvalid` bit 0 marks `eng_param0` valid and bit 1 marks `eng_param1` valid. The code 2'b10 never appears.
- R4: After the done pulse of 0x11 in the init script, the next request is raised 150×`CLK_PER_MS`+1 cycles after the cycle in which done was presented. Between any other two steps the gap is 1 cycle.
- R5: A suspend request (`stby_suspend`=1) sends 0x10, then waits 120×`CLK_PER_MS` cycles after its done, then sends 0x28. Neither step has parameters.
- R6: A resume request (`stby_suspend`=0) sends 0x29 and then 0x11, with no parameters and a 1-cycle gap. Its first request is visible the cycle after the request is sampled.
- R7: While `eng_valid` is high and `eng_ready` is low, the request and all its fields stay unchanged.
- R8: After a transfer, `eng_valid` stays low until `eng_done` is sampled.
- R9: `busy` rises the cycle after a request is accepted. It falls the cycle after the last step's done is sampled, and `eng_valid` is only high while `busy` is high.
- R10: `init_req` and `stby_req` have no effect while `busy` is high: the step sequence and the reset line are unchanged.
- R11: When `init_req` and `stby_req` are sampled together in idle, the init sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the power-up sequence (sampled when idle) |
| stby_req | input | 1 | Start a standby-change sequence (sampled when idle) |
| stby_suspend | input | 1 | With `stby_req`: 1 = suspend, 0 = resume |
| busy | output | 1 | A sequence is in progress |
| panel_rst_n | output | 1 | Active-low panel reset |
| eng_valid | output | 1 | Command request to the serial engine |
| eng_ready | input | 1 | Engine accepts the request |
| eng_cmd | output | 8 | Command byte |
| eng_param0 | output | 8 | First parameter byte |
| eng_param1 | output | 8 | Second parameter byte |
| eng_pvalid | output | 2 | Parameter-valid flags (bit 0 first, bit 1 second) |
| eng_done | input | 1 | Engine has finished the transferred step |

## Verification
The bench builds the block with `CLK_PER_MS` = 3 and the default millisecond counts. The 150 ms wake wait therefore shrinks to 450 cycles, and a whole init run fits in about 500 cycles. This makes it possible to measure every reset, settle and inter-step gap to the exact cycle. It runs all three scripts under every pairing of engine ready latency and done latency from 0 to 2 cycles. It also checks simultaneous requests and requests injected while a sequence is running.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  // delay applied after a step's done pulse, before the next step
  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_WAKE = 2'd1,
    W_SUSP = 2'd2
  } wait_e;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] p0;
    logic [7:0] p1;
    logic [1:0] pv;
    wait_e      wsel;
    logic       last;
  } step_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RSTLO = 3'd1,
    S_RSTHI = 3'd2,
    S_ISSUE = 3'd3,
    S_WAITD = 3'd4,
    S_DELAY = 3'd5
  } st_e;

  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W-1:0] INIT_BASE = 4'd0;
  localparam logic [IDX_W-1:0] SUSP_BASE = 4'd7;
  localparam logic [IDX_W-1:0] RES_BASE  = 4'd9;

endpackage

// File: rtl/panel_seq_script.sv
module panel_seq_script
  import panel_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  function automatic step_t mk(logic [7:0] c, logic [7:0] a, logic [7:0] b,
                               logic [1:0] v, wait_e w, logic l);
    step_t s;
    s.cmd  = c;
    s.p0   = a;
    s.p1   = b;
    s.pv   = v;
    s.wsel = w;
    s.last = l;
    return s;
  endfunction

  always_comb begin
    case (idx)
      // power-up script
      4'd0:    step = mk(8'h29, 8'h00, 8'h00, 2'b00, W_NONE, 1'b0);
      4'd1:    step = mk(8'h11, 8'h00, 8'h00, 2'b00, W_WAKE, 1'b0);
      4'd2:    step = mk(8'h36, 8'h00, 8'h00, 2'b01, W_NONE, 1'b0);
      4'd3:    step = mk(8'h3A, 8'h70, 8'h00, 2'b01, W_NONE, 1'b0);
      4'd4:    step = mk(8'hB0, 8'h00, 8'h00, 2'b01, W_NONE, 1'b0);
      4'd5:    step = mk(8'hB8, 8'h00, 8'h00, 2'b01, W_NONE, 1'b0);
      4'd6:    step = mk(8'hB9, 8'h01, 8'hFF, 2'b11, W_NONE, 1'b1);
      // suspend script
      4'd7:    step = mk(8'h10, 8'h00, 8'h00, 2'b00, W_SUSP, 1'b0);
      4'd8:    step = mk(8'h28, 8'h00, 8'h00, 2'b00, W_NONE, 1'b1);
      // resume script
      4'd9:    step = mk(8'h29, 8'h00, 8'h00, 2'b00, W_NONE, 1'b0);
      4'd10:   step = mk(8'h11, 8'h00, 8'h00, 2'b00, W_NONE, 1'b1);
      default: step = mk(8'h00, 8'h00, 8'h00, 2'b00, W_NONE, 1'b1);
    endcase
  end

endmodule

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
  parameter int unsigned CLK_PER_MS = 125000,
  parameter int unsigned MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] ms_val,
  output logic            expire
);

  localparam int unsigned PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;
  logic             tick;

  assign tick   = run_q && (pre_q == PRE_LAST);
  assign expire = tick && (ms_q == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      pre_q <= '0;
      ms_q  <= ms_val;
      run_q <= 1'b1;
    end else if (tick) begin
      pre_q <= '0;
      ms_q  <= ms_q - MS_W'(1);
      if (ms_q == MS_W'(1)) run_q <= 1'b0;
    end else if (run_q) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int unsigned MS_W          = 8,
  parameter int unsigned RST_LOW_MS    = 2,
  parameter int unsigned RST_SETTLE_MS = 10,
  parameter int unsigned WAKE_MS       = 150,
  parameter int unsigned SUSP_MS       = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             stby_req,
  input  logic             stby_suspend,
  input  logic             eng_ready,
  input  logic             eng_done,
  input  wait_e            step_wsel,
  input  logic             step_last,
  input  logic             tim_expire,
  output logic [IDX_W-1:0] idx,
  output st_e              state,
  output logic             tim_load,
  output logic [MS_W-1:0]  tim_ms,
  output logic             panel_rst_n
);

  st_e              st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             prst_q;

  function automatic logic [MS_W-1:0] wait_ms(wait_e w);
    case (w)
      W_WAKE:  return MS_W'(WAKE_MS);
      W_SUSP:  return MS_W'(SUSP_MS);
      default: return MS_W'(1);
    endcase
  endfunction

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    tim_load = 1'b0;
    tim_ms   = MS_W'(RST_LOW_MS);
    case (st_q)
      S_IDLE: begin
        if (init_req) begin
          st_n     = S_RSTLO;
          tim_load = 1'b1;
          tim_ms   = MS_W'(RST_LOW_MS);
        end else if (stby_req) begin
          st_n  = S_ISSUE;
          idx_n = stby_suspend ? SUSP_BASE : RES_BASE;
        end
      end
      S_RSTLO: begin
        if (tim_expire) begin
          st_n     = S_RSTHI;
          tim_load = 1'b1;
          tim_ms   = MS_W'(RST_SETTLE_MS);
        end
      end
      S_RSTHI: begin
        if (tim_expire) begin
          st_n  = S_ISSUE;
          idx_n = INIT_BASE;
        end
      end
      S_ISSUE: begin
        if (eng_ready) st_n = S_WAITD;
      end
      S_WAITD: begin
        if (eng_done) begin
          if (step_last) begin
            st_n = S_IDLE;
          end else begin
            idx_n = idx_q + IDX_W'(1);
            if (step_wsel != W_NONE) begin
              st_n     = S_DELAY;
              tim_load = 1'b1;
              tim_ms   = wait_ms(step_wsel);
            end else begin
              st_n = S_ISSUE;
            end
          end
        end
      end
      S_DELAY: begin
        if (tim_expire) st_n = S_ISSUE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      prst_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      prst_q <= (st_n != S_RSTLO);
    end
  end

  assign idx         = idx_q;
  assign state       = st_q;
  assign panel_rst_n = prst_q;

endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
  import panel_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_MS    = 125000,
  parameter int unsigned RST_LOW_MS    = 2,
  parameter int unsigned RST_SETTLE_MS = 10,
  parameter int unsigned WAKE_MS       = 150,
  parameter int unsigned SUSP_MS       = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       stby_req,
  input  logic       stby_suspend,
  output logic       busy,
  output logic       panel_rst_n,
  output logic       eng_valid,
  input  logic       eng_ready,
  output logic [7:0] eng_cmd,
  output logic [7:0] eng_param0,
  output logic [7:0] eng_param1,
  output logic [1:0] eng_pvalid,
  input  logic       eng_done
);

  localparam int unsigned MAX_A  = (RST_LOW_MS > RST_SETTLE_MS) ? RST_LOW_MS : RST_SETTLE_MS;
  localparam int unsigned MAX_B  = (WAKE_MS > SUSP_MS) ? WAKE_MS : SUSP_MS;
  localparam int unsigned MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

  logic [IDX_W-1:0] idx;
  step_t            step;
  st_e              state;
  logic             tim_load;
  logic [MS_W-1:0]  tim_ms;
  logic             tim_expire;

  panel_seq_script u_script (
    .idx  (idx),
    .step (step)
  );

  panel_seq_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_W       (MS_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tim_load),
    .ms_val (tim_ms),
    .expire (tim_expire)
  );

  panel_seq_ctrl #(
    .MS_W          (MS_W),
    .RST_LOW_MS    (RST_LOW_MS),
    .RST_SETTLE_MS (RST_SETTLE_MS),
    .WAKE_MS       (WAKE_MS),
    .SUSP_MS       (SUSP_MS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_req     (init_req),
    .stby_req     (stby_req),
    .stby_suspend (stby_suspend),
    .eng_ready    (eng_ready),
    .eng_done     (eng_done),
    .step_wsel    (step.wsel),
    .step_last    (step.last),
    .tim_expire   (tim_expire),
    .idx          (idx),
    .state        (state),
    .tim_load     (tim_load),
    .tim_ms       (tim_ms),
    .panel_rst_n  (panel_rst_n)
  );

  assign busy       = (state != S_IDLE);
  assign eng_valid  = (state == S_ISSUE);
  assign eng_cmd    = step.cmd;
  assign eng_param0 = step.p0;
  assign eng_param1 = step.p1;
  assign eng_pvalid = step.pv;

endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       panel_rst_n,
  input logic       eng_valid,
  input logic       eng_ready,
  input logic [7:0] eng_cmd,
  input logic [7:0] eng_param0,
  input logic [7:0] eng_param1,
  input logic [1:0] eng_pvalid,
  input logic       eng_done
);

  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      outstanding <= 1'b0;
    else if (eng_valid && eng_ready) outstanding <= 1'b1;
    else if (eng_done)               outstanding <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_cmd) && $stable(eng_param0)
      && $stable(eng_param1) && $stable(eng_pvalid)); // R7

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> busy); // R9

  AST_IDLE_RST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> panel_rst_n); // R2

  AST_NO_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !eng_valid); // R2

  AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !eng_valid); // R8

  AST_PVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> (eng_pvalid != 2'b10)); // R3

endmodule

bind panel_seq_top panel_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .panel_rst_n (panel_rst_n),
  .eng_valid   (eng_valid),
  .eng_ready   (eng_ready),
  .eng_cmd     (eng_cmd),
  .eng_param0  (eng_param0),
  .eng_param1  (eng_param1),
  .eng_pvalid  (eng_pvalid),
  .eng_done    (eng_done)
);

// File: tb/panel_seq_top_tb.sv
module panel_seq_top_tb;

  localparam int CPM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, stby_req = 1'b0, stby_suspend = 1'b0;
  logic busy, panel_rst_n, eng_valid, eng_ready, eng_done;
  logic [7:0] eng_cmd, eng_param0, eng_param1;
  logic [1:0] eng_pvalid;

  always #4 clk = ~clk;

  panel_seq_top #(.CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .stby_req(stby_req),
    .stby_suspend(stby_suspend), .busy(busy), .panel_rst_n(panel_rst_n),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_cmd(eng_cmd),
    .eng_param0(eng_param0), .eng_param1(eng_param1), .eng_pvalid(eng_pvalid),
    .eng_done(eng_done)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // engine model and log
  int rdy_lat = 0, done_lat = 0;
  int n = 0, hold_err = 0, early_err = 0;
  logic [7:0] cmd_l[16], p0_l[16], p1_l[16];
  logic [1:0] pv_l[16];
  int vis_cyc[16], done_cyc[16];

  initial begin
    eng_ready = 1'b0;
    eng_done  = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_valid && n < 16) begin
        cmd_l[n] = eng_cmd; p0_l[n] = eng_param0; p1_l[n] = eng_param1;
        pv_l[n] = eng_pvalid; vis_cyc[n] = cyc;
        for (int k = 0; k < rdy_lat; k++) begin
          @(negedge clk);
          if (!eng_valid || eng_cmd !== cmd_l[n] || eng_param0 !== p0_l[n] ||
              eng_param1 !== p1_l[n] || eng_pvalid !== pv_l[n]) hold_err++;
        end
        eng_ready = 1'b1;
        @(negedge clk);
        eng_ready = 1'b0;
        if (eng_valid) early_err++;
        for (int k = 0; k < done_lat; k++) begin
          @(negedge clk);
          if (eng_valid) early_err++;
        end
        eng_done = 1'b1;
        done_cyc[n] = cyc;
        n++;
      end
    end
  end

  // reset line and busy monitor
  int fall_cyc = -1, rise_cyc = -1, falls = 0, bsy_fall = -1;
  logic prev_prst = 1'b1, prev_busy = 1'b0;
  always @(negedge clk) begin
    if (prev_prst && !panel_rst_n) begin fall_cyc = cyc; falls++; end
    if (!prev_prst && panel_rst_n) rise_cyc = cyc;
    if (prev_busy && !busy) bsy_fall = cyc;
    prev_prst = panel_rst_n;
    prev_busy = busy;
  end

  // expected scripts: s = 0 init, 1 suspend, 2 resume
  function automatic int exp_len(int s);
    return (s == 0) ? 7 : 2;
  endfunction
  function automatic int exp_cmd(int s, int i);
    if (s == 1) return (i == 0) ? 'h10 : 'h28;
    if (s == 2) return (i == 0) ? 'h29 : 'h11;
    case (i)
      0: return 'h29;  1: return 'h11;  2: return 'h36;  3: return 'h3A;
      4: return 'hB0;  5: return 'hB8;  default: return 'hB9;
    endcase
  endfunction
  function automatic int exp_pv(int s, int i);
    if (s != 0 || i < 2) return 0;
    return (i == 6) ? 3 : 1;
  endfunction
  function automatic int exp_p0(int s, int i);
    if (s == 0 && i == 3) return 'h70;
    if (s == 0 && i == 6) return 'h01;
    return 0;
  endfunction
  function automatic int exp_gap(int s, int i);
    if (s == 0 && i == 2) return 150 * CPM + 1;
    if (s == 1 && i == 1) return 120 * CPM + 1;
    return 1;
  endfunction

  // kind: 0 init, 1 suspend, 2 resume, 3 init+standby together
  task automatic run(input int kind, input int rl, input int dl, input bit inject);
    int s, req_cyc, t, n_end;
    s = (kind == 3) ? 0 : kind;
    rdy_lat = rl; done_lat = dl;
    n = 0; hold_err = 0; early_err = 0; falls = 0; bsy_fall = -1;
    fall_cyc = -1; rise_cyc = -1;
    @(negedge clk);
    req_cyc = cyc;
    init_req     = (kind == 0 || kind == 3);
    stby_req     = (kind == 1 || kind == 2 || kind == 3);
    stby_suspend = (kind == 1 || kind == 3);
    @(negedge clk);
    init_req = 1'b0; stby_req = 1'b0;
    chk(busy === 1'b1, "R9 busy after request", busy, 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      init_req = 1'b1; stby_req = 1'b1; stby_suspend = 1'b0;
      @(negedge clk);
      init_req = 1'b0; stby_req = 1'b0;
    end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(n == exp_len(s), inject ? "R10 step count" : "R3 R5 R6 step count", n, exp_len(s));
    for (int i = 0; i < exp_len(s) && i < n; i++) begin
      chk(cmd_l[i] == exp_cmd(s, i), "R3 R5 R6 command", cmd_l[i], exp_cmd(s, i));
      chk(pv_l[i] == exp_pv(s, i), "R3 pvalid", pv_l[i], exp_pv(s, i));
      if (pv_l[i][0]) chk(p0_l[i] == exp_p0(s, i), "R3 param0", p0_l[i], exp_p0(s, i));
      if (pv_l[i][1]) chk(p1_l[i] == 'hFF, "R3 param1", p1_l[i], 'hFF);
      if (i > 0)
        chk(vis_cyc[i] - done_cyc[i-1] == exp_gap(s, i), "R4 R5 R6 gap",
            vis_cyc[i] - done_cyc[i-1], exp_gap(s, i));
    end
    if (s == 0) begin
      chk(falls == 1, inject ? "R10 reset pulses" : "R2 R11 reset pulses", falls, 1);
      chk(fall_cyc == req_cyc + 1, "R2 reset start", fall_cyc, req_cyc + 1);
      chk(rise_cyc - fall_cyc == 2 * CPM, "R2 reset width", rise_cyc - fall_cyc, 2 * CPM);
      chk(vis_cyc[0] - rise_cyc == 10 * CPM, "R2 settle", vis_cyc[0] - rise_cyc, 10 * CPM);
    end else begin
      chk(falls == 0, "R6 no reset pulse", falls, 0);
      chk(vis_cyc[0] == req_cyc + 1, "R6 first step", vis_cyc[0], req_cyc + 1);
    end
    chk(hold_err == 0, "R7 hold", hold_err, 0);
    chk(early_err == 0, "R8 wait done", early_err, 0);
    if (n > 0)
      chk(bsy_fall == done_cyc[n-1] + 1, "R9 busy fall", bsy_fall, done_cyc[n-1] + 1);
    n_end = n;
    repeat (10) @(negedge clk);
    chk(n == n_end && !busy, "R10 quiet after end", n, n_end);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(panel_rst_n === 1'b1, "R1 panel reset", panel_rst_n, 1);
    chk(eng_valid === 1'b0, "R1 valid", eng_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && eng_valid === 1'b0, "R1 idle after reset", busy, 0);
    for (int k = 0; k < 3; k++)
      for (int rl = 0; rl < 3; rl++)
        for (int dl = 0; dl < 3; dl++)
          run(k, rl, dl, 1'b0);
    run(3, 1, 0, 1'b0);   // R11 priority
    run(0, 0, 1, 1'b1);   // R10 requests while busy
    run(2, 2, 2, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule